// File: doc/BRIEF.md
# Debug Hardware Command Executor

This block sits behind the serial receive/transmit layer of an on-chip debug port and carries out the hardware class of debug commands while the processor keeps executing. A host sends a one-byte opcode, then the target address as two bytes (high byte first). A write command then sends two data bytes. A read command gets two data bytes back, high byte first. The executor performs the access on a single-cycle bus master port. It waits for a cycle that the processor leaves free. If no free cycle appears within a set number of clocks, it takes the bus anyway and holds the processor frozen for that one cycle.

Each read and write opcode comes in two variants. One has the debug register window mapped in and the other has it mapped out. The window state travels with every bus access. The debug status byte is held inside the block. A window-mapped byte access to its address, or a window-mapped word access to the aligned word that contains it, is answered locally and never reaches the bus. The status byte carries an enable flag and an active flag. A host sets the enable flag by writing a byte with bit 7 set. The background-entry opcode then marks debug as active.

Top module: `bdx_hw_exec`

## Requirements
- R1: Only the opcodes 0x90, 0xE0, 0xE4, 0xE8, 0xEC, 0xC0, 0xC4, 0xC8 and 0xCC are accepted in the idle state. Any other byte there is dropped: it causes no bus access and no reply, and the next byte is again taken as an opcode.
- R2: A read command (0xE0, 0xE4, 0xE8, 0xEC) is the opcode followed by address high and address low. It returns two reply bytes on consecutive cycles, high first. A write command (0xC0, 0xC4, 0xC8, 0xCC) adds data high and data low. It issues one bus write with that address and data and returns no reply.
- R3: Byte commands (0xE0, 0xE4, 0xC0, 0xC4) steer by address parity. An odd address uses byte enable 2'b01 (low lane) and an even address uses 2'b10 (high lane). A byte read returns zero in the lane that was not selected.
- R4: Word commands (0xE8, 0xEC, 0xC8, 0xCC) use byte enable 2'b11 on an even address. A word command with an odd address makes no bus access and sets `cmd_err`, which stays set until reset. Its write data is still consumed, and as a read it returns 0x0000.
- R5: Opcodes with bit 2 set (0xE4, 0xEC, 0xC4, 0xCC) drive `bus_win` high. The others drive it low.
- R6: A window-mapped byte access to STATUS_ADDR (default 0xFF01), or a window-mapped word access to STATUS_ADDR with bit 0 cleared, is served inside the block with no bus access. A read returns 0x00 in the high byte and the status byte in the low byte. The same addresses with the window mapped out go to the bus.
- R7: Status bit 7 (enable) takes bit 7 of the data low byte on a write that hits the status register. Bits 5 to 0 always read as zero.
- R8: Opcode 0x90 sets status bit 6 (active) only when bit 7 is already set. Otherwise it has no effect. Once set, bit 6 stays set until reset.
- R9: When `bus_idle` is high in a cycle where an access is pending, the access is issued in that cycle and `cpu_freeze` stays low.
- R10: If `bus_idle` stays low, the access is issued with `cpu_freeze` high in the STEAL_WAIT-th pending cycle (default 128). The freeze lasts exactly that one cycle.
- R11: After reset the status byte is 0x00, and `cmd_err`, `bus_req`, `tx_valid` and `cpu_freeze` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | A reply byte is presented this cycle |
| tx_byte | output | 8 | Reply byte |
| bus_req | output | 1 | Single-cycle bus access strobe |
| bus_we | output | 1 | Access is a write |
| bus_win | output | 1 | Debug register window mapped in for this access |
| bus_addr | output | 16 | Access address |
| bus_wdata | output | 16 | Write data |
| bus_be | output | 2 | Byte enables, bit 1 high lane, bit 0 low lane |
| bus_rdata | input | 16 | Read data, valid in the strobe cycle |
| bus_idle | input | 1 | The processor leaves the bus free this cycle |
| cpu_freeze | output | 1 | Processor held for a stolen cycle |
| dbg_status | output | 8 | Debug status byte |
| cmd_err | output | 1 | Sticky misaligned-word error |

## Verification
The bench checks lane steering at both address parities. A design that ignores parity returns or writes the wrong half of the word. It sends misaligned word commands, where a faulty design would touch the bus or lose byte framing. It checks the status address both with the window mapped in and with it mapped out, so a decoder that ignores the window state either leaks status writes to memory or hides memory behind the register. It also sends the background opcode before and after enabling it. With the bus held busy, the bench measures the exact cycle of the stolen access. An off-by-one timer shows up as a count one away from STEAL_WAIT, and a stuck freeze fails the single-cycle rule.

// File: rtl/bdx_pkg.sv
// Shared types for the debug hardware command executor.
// Assumes opcodes arrive as whole bytes from the serial layer.
package bdx_pkg;

    // Attributes of one decoded opcode
    typedef struct packed {
        logic valid;   // opcode is one the executor handles
        logic bgnd;    // background-entry request
        logic write;   // carries data in, no reply
        logic word;    // 16-bit access, needs even address
        logic in_map;  // debug window mapped in
    } cmd_attr_t;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR_HI, S_ADDR_LO, S_DATA_HI, S_DATA_LO,
        S_ACCESS, S_SEND_HI, S_SEND_LO
    } exec_state_t;

    // Map an opcode byte onto its attributes
    function automatic cmd_attr_t decode_op(input logic [7:0] op);
        cmd_attr_t a;
        a = '0;
        case (op)
            8'h90: begin a.valid = 1'b1; a.bgnd = 1'b1; end
            8'hE0, 8'hE4, 8'hE8, 8'hEC,
            8'hC0, 8'hC4, 8'hC8, 8'hCC: begin
                a.valid  = 1'b1;
                a.write  = ~op[5];
                a.word   = op[3];
                a.in_map = op[2];
            end
            default: a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/bdx_cmd_decode.sv
// Opcode decoder: turns a received byte into command attributes.
// Purely combinational; unknown bytes decode with valid low.
module bdx_cmd_decode
    import bdx_pkg::*;
(
    input  logic [7:0] op,
    output cmd_attr_t  attr
);
    // Table lookup of the opcode
    always_comb attr = decode_op(op);
endmodule

// File: rtl/bdx_steal_timer.sv
// Cycle-steal timer: grants an access on a free bus cycle, or forces
// one after WAIT_CYC pending cycles. Assumes wait_en drops after grant.
module bdx_steal_timer #(
    parameter int WAIT_CYC = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_en,
    input  logic bus_idle,
    output logic grant,
    output logic steal
);
    localparam int CW = $clog2(WAIT_CYC) + 1;
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

    logic [CW-1:0] cnt;

    // Force the access once the budget of busy cycles is spent
    always_comb begin
        steal = wait_en && !bus_idle && (cnt == LAST);
        grant = wait_en && (bus_idle || steal);
    end

    // Count pending cycles that found no free slot
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (wait_en && !grant) cnt <= cnt + 1'b1;
        else                      cnt <= '0;
    end
endmodule

// File: rtl/bdx_dbg_status.sv
// Debug status byte: enable flag (bit 7) written by host, active flag
// (bit 6) set by background request when enabled. Other bits read 0.
module bdx_dbg_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_enable,
    input  logic       bgnd_req,
    output logic [7:0] status
);
    logic enable_q;
    logic active_q;

    // Hold the two flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            active_q <= 1'b0;
        end else begin
            if (wr_en)                 enable_q <= wr_enable;
            if (bgnd_req && enable_q)  active_q <= 1'b1;
        end
    end

    // Assemble the readable byte
    always_comb status = {enable_q, active_q, 6'b0};
endmodule

// File: rtl/bdx_hw_exec.sv
// Debug hardware command executor. Collects opcode, address and data
// bytes, runs one bus access on a free or stolen cycle, answers status
// accesses locally and returns read data as two bytes, high first.
// Assumes the serial layer accepts a reply byte in every cycle.
module bdx_hw_exec
    import bdx_pkg::*;
#(
    parameter int          STEAL_WAIT  = 128,
    parameter logic [15:0] STATUS_ADDR = 16'hFF01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic        bus_req,
    output logic        bus_we,
    output logic        bus_win,
    output logic [15:0] bus_addr,
    output logic [15:0] bus_wdata,
    output logic [1:0]  bus_be,
    input  logic [15:0] bus_rdata,
    input  logic        bus_idle,
    output logic        cpu_freeze,
    output logic [7:0]  dbg_status,
    output logic        cmd_err
);
    localparam logic [15:0] STATUS_WORD = {STATUS_ADDR[15:1], 1'b0};

    exec_state_t state;
    cmd_attr_t   dec, attr_q;
    logic [15:0] addr_q, data_q;
    logic        err_q;
    logic        misalign, stat_hit, wait_en, grant, steal;
    logic        stat_wr, bgnd_req;
    logic [1:0]  lane_be;
    logic [15:0] rd_mask;
    exec_state_t after_acc;

    bdx_cmd_decode u_dec (.op(rx_byte), .attr(dec));

    bdx_steal_timer #(.WAIT_CYC(STEAL_WAIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .wait_en(wait_en), .bus_idle(bus_idle),
        .grant(grant), .steal(steal)
    );

    bdx_dbg_status u_stat (
        .clk(clk), .rst_n(rst_n), .wr_en(stat_wr), .wr_enable(data_q[7]),
        .bgnd_req(bgnd_req), .status(dbg_status)
    );

    // Classify the pending access and steer the byte lanes
    always_comb begin
        misalign  = attr_q.word && addr_q[0];
        stat_hit  = attr_q.in_map &&
                    (attr_q.word ? (addr_q == STATUS_WORD) : (addr_q == STATUS_ADDR));
        wait_en   = (state == S_ACCESS) && !misalign && !stat_hit;
        lane_be   = attr_q.word ? 2'b11 : (addr_q[0] ? 2'b01 : 2'b10);
        rd_mask   = {{8{lane_be[1]}}, {8{lane_be[0]}}};
        stat_wr   = (state == S_ACCESS) && stat_hit && attr_q.write;
        bgnd_req  = (state == S_IDLE) && rx_valid && dec.bgnd;
        after_acc = attr_q.write ? S_IDLE : S_SEND_HI;
    end

    // Drive the bus, freeze and reply ports
    always_comb begin
        bus_req    = grant;
        bus_we     = attr_q.write;
        bus_win    = attr_q.in_map;
        bus_addr   = addr_q;
        bus_wdata  = data_q;
        bus_be     = lane_be;
        cpu_freeze = steal;
        tx_valid   = (state == S_SEND_HI) || (state == S_SEND_LO);
        tx_byte    = (state == S_SEND_HI) ? data_q[15:8] : data_q[7:0];
        cmd_err    = err_q;
    end

    // Command sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            attr_q <= '0;
            addr_q <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (rx_valid && dec.valid && !dec.bgnd) begin
                    attr_q <= dec;
                    state  <= S_ADDR_HI;
                end
                S_ADDR_HI: if (rx_valid) begin
                    addr_q[15:8] <= rx_byte;
                    state        <= S_ADDR_LO;
                end
                S_ADDR_LO: if (rx_valid) begin
                    addr_q[7:0] <= rx_byte;
                    state       <= attr_q.write ? S_DATA_HI : S_ACCESS;
                end
                S_DATA_HI: if (rx_valid) begin
                    data_q[15:8] <= rx_byte;
                    state        <= S_DATA_LO;
                end
                S_DATA_LO: if (rx_valid) begin
                    data_q[7:0] <= rx_byte;
                    state       <= S_ACCESS;
                end
                S_ACCESS: begin
                    if (misalign) begin
                        err_q  <= 1'b1;
                        data_q <= '0;
                        state  <= after_acc;
                    end else if (stat_hit) begin
                        if (!attr_q.write) data_q <= {8'h00, dbg_status};
                        state <= after_acc;
                    end else if (grant) begin
                        if (!attr_q.write) data_q <= bus_rdata & rd_mask;
                        state <= after_acc;
                    end
                end
                S_SEND_HI: state <= S_SEND_LO;
                default:   state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bdx_hw_exec_chk.sv
// Property checker for the command executor, attached by bind.
module bdx_hw_exec_chk #(
    parameter int STEAL_WAIT = 128
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_req,
    input logic       bus_idle,
    input logic       cpu_freeze,
    input logic [1:0] bus_be,
    input logic [15:0] bus_addr,
    input logic [7:0] dbg_status,
    input logic       cmd_err,
    input logic       wait_en,
    input logic       tx_valid
);
    int unsigned wait_run;

    // Length of the current run of pending cycles without an access
    always_ff @(posedge clk) begin
        if (!rst_n)                   wait_run <= 0;
        else if (wait_en && !bus_req) wait_run <= wait_run + 1;
        else                          wait_run <= 0;
    end

    a_r10_freeze_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_freeze |-> bus_req);
    a_r10_freeze_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_freeze |=> !cpu_freeze);
    a_r10_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        wait_en |-> (wait_run < STEAL_WAIT));
    a_r9_idle_no_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_idle) |-> !cpu_freeze);
    a_r3_lane_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $countones(bus_be) == 1) |-> (bus_be[0] == bus_addr[0]));
    a_r4_word_even: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_be == 2'b11) |-> !bus_addr[0]);
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);
    a_r8_active_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_status[6] && !$past(dbg_status[6])) |-> $past(dbg_status[7]));
    a_r8_active_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_status[6] |=> dbg_status[6]);
    a_r7_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_status[5:0] == 6'b0);
    a_r2_no_reply_during_access: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !tx_valid);
endmodule

bind bdx_hw_exec bdx_hw_exec_chk #(.STEAL_WAIT(STEAL_WAIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_idle(bus_idle),
    .cpu_freeze(cpu_freeze), .bus_be(bus_be), .bus_addr(bus_addr),
    .dbg_status(dbg_status), .cmd_err(cmd_err), .wait_en(wait_en),
    .tx_valid(tx_valid)
);

// File: tb/test_bdx_hw_exec.sv
// Scoreboard bench: driver tasks queue expected replies and bus writes,
// negedge monitors pop and compare them.
module test_bdx_hw_exec;
    localparam int STEAL_WAIT = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        bus_req, bus_we, bus_win, cpu_freeze, cmd_err;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_be;
    logic        bus_idle = 1'b1;
    logic [7:0]  dbg_status;

    int checks = 0;
    int fails  = 0;
    int bus_cnt = 0;
    int tx_cnt  = 0;
    bit done = 1'b0;

    logic [15:0] exp_rd[$];
    string       rd_tag[$];
    logic [34:0] exp_wr[$];
    string       wr_tag[$];
    logic        tx_have = 1'b0;
    logic [7:0]  tx_hi = 8'h00;

    always #2 clk = ~clk;

    // Memory model: data depends on window and word address
    function automatic logic [15:0] mem_model(input logic win, input logic [15:0] a);
        return ({a[15:1], 1'b0} ^ (win ? 16'hA5C3 : 16'h3C96)) + 16'h0111;
    endfunction

    assign bus_rdata = mem_model(bus_win, bus_addr);

    bdx_hw_exec #(.STEAL_WAIT(STEAL_WAIT)) i_bdx_hw_exec (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .bus_req(bus_req),
        .bus_we(bus_we), .bus_win(bus_win), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .bus_idle(bus_idle), .cpu_freeze(cpu_freeze),
        .dbg_status(dbg_status), .cmd_err(cmd_err)
    );

    task automatic chk(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: reply bytes and bus accesses against the queues
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (bus_req) begin
                bus_cnt++;
                if (bus_idle) chk(!cpu_freeze, "R9 freeze on idle cycle", 36'(cpu_freeze), 36'h0);
                if (bus_we) begin
                    if (exp_wr.size() == 0) chk(1'b0, "R2 unexpected bus write", {bus_win, bus_be, bus_addr, bus_wdata}, 36'h0);
                    else begin
                        logic [34:0] e;
                        string t;
                        e = exp_wr.pop_front();
                        t = wr_tag.pop_front();
                        chk({bus_win, bus_be, bus_addr, bus_wdata} == e, t,
                            36'({bus_win, bus_be, bus_addr, bus_wdata}), 36'(e));
                    end
                end
            end
            if (tx_valid) begin
                tx_cnt++;
                if (!tx_have) begin
                    tx_hi = tx_byte;
                    tx_have = 1'b1;
                end else begin
                    tx_have = 1'b0;
                    if (exp_rd.size() == 0) chk(1'b0, "R2 unexpected reply", 36'({tx_hi, tx_byte}), 36'h0);
                    else begin
                        logic [15:0] e;
                        string t;
                        e = exp_rd.pop_front();
                        t = rd_tag.pop_front();
                        chk({tx_hi, tx_byte} == e, t, 36'({tx_hi, tx_byte}), 36'(e));
                    end
                end
            end
        end
    end

    task automatic send(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic cmd_read(input logic [7:0] op, input logic [15:0] a,
                            input logic [15:0] e, input string tag);
        exp_rd.push_back(e);
        rd_tag.push_back(tag);
        send(op); send(a[15:8]); send(a[7:0]);
        repeat (6) @(negedge clk);
    endtask

    task automatic cmd_write(input logic [7:0] op, input logic [15:0] a,
                             input logic [15:0] d, input bit expect_bus,
                             input logic [1:0] be, input string tag);
        if (expect_bus) begin
            exp_wr.push_back({op[2], be, a, d});
            wr_tag.push_back(tag);
        end
        send(op); send(a[15:8]); send(a[7:0]); send(d[15:8]); send(d[7:0]);
        repeat (6) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int b0;
        int t0;
        repeat (5) @(negedge clk);
        // R11 reset state
        chk(dbg_status == 8'h00, "R11 status after reset", 36'(dbg_status), 36'h0);
        chk(!cmd_err && !bus_req && !tx_valid && !cpu_freeze, "R11 outputs after reset",
            36'({cmd_err, bus_req, tx_valid, cpu_freeze}), 36'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R5 word reads in and out of the window
        cmd_read(8'hE8, 16'h1234, mem_model(1'b0, 16'h1234), "R5 word read window out");
        cmd_read(8'hEC, 16'h1234, mem_model(1'b1, 16'h1234), "R5 word read window in");
        // R3 byte lanes
        cmd_read(8'hE0, 16'h2345, {8'h00, mem_model(1'b0, 16'h2345)[7:0]}, "R3 odd byte read low lane");
        cmd_read(8'hE4, 16'h2346, {mem_model(1'b1, 16'h2346)[15:8], 8'h00}, "R3 even byte read high lane");
        // R2 R3 writes
        cmd_write(8'hC8, 16'h4000, 16'hBEEF, 1'b1, 2'b11, "R2 word write");
        cmd_write(8'hC4, 16'h4001, 16'h00AB, 1'b1, 2'b01, "R3 odd byte write low lane");
        cmd_write(8'hC0, 16'h4002, 16'hCD00, 1'b1, 2'b10, "R3 even byte write high lane");

        // R6 status read without bus
        b0 = bus_cnt;
        cmd_read(8'hE4, 16'hFF01, 16'h0000, "R6 status read at reset");
        // R8 background while disabled
        send(8'h90);
        repeat (3) @(negedge clk);
        chk(dbg_status == 8'h00, "R8 background ignored when disabled", 36'(dbg_status), 36'h0);
        // R7 enable
        cmd_write(8'hC4, 16'hFF01, 16'h0080, 1'b0, 2'b01, "");
        chk(dbg_status == 8'h80, "R7 enable set by write", 36'(dbg_status), 36'h80);
        cmd_read(8'hE4, 16'hFF01, 16'h0080, "R7 status reads enabled");
        chk(bus_cnt == b0, "R6 status accesses stay off bus", 36'(bus_cnt), 36'(b0));
        // R8 background while enabled
        send(8'h90);
        repeat (3) @(negedge clk);
        cmd_read(8'hEC, 16'hFF00, 16'h00C0, "R8 active after background");
        // R6 window out goes to bus
        b0 = bus_cnt;
        cmd_read(8'hE0, 16'hFF01, {8'h00, mem_model(1'b0, 16'hFF01)[7:0]}, "R6 status address out of window");
        chk(bus_cnt == b0 + 1, "R6 out-of-window access on bus", 36'(bus_cnt), 36'(b0 + 1));
        // R7 R8 clear enable, active stays
        cmd_write(8'hCC, 16'hFF00, 16'h1200, 1'b0, 2'b11, "");
        chk(dbg_status == 8'h40, "R7 enable cleared, R8 active kept", 36'(dbg_status), 36'h40);

        // R1 unknown opcode dropped
        b0 = bus_cnt;
        t0 = tx_cnt;
        send(8'h55);
        repeat (3) @(negedge clk);
        chk(bus_cnt == b0 && tx_cnt == t0, "R1 unknown opcode no activity",
            36'({bus_cnt[15:0], tx_cnt[15:0]}), 36'({b0[15:0], t0[15:0]}));
        cmd_read(8'hE8, 16'h0A0A, mem_model(1'b0, 16'h0A0A), "R1 framing after unknown opcode");

        // R4 misaligned words
        b0 = bus_cnt;
        chk(!cmd_err, "R4 error clear before misalign", 36'(cmd_err), 36'h0);
        cmd_write(8'hC8, 16'h4001, 16'h5678, 1'b0, 2'b11, "");
        chk(cmd_err, "R4 error set by misaligned write", 36'(cmd_err), 36'h1);
        cmd_read(8'hEC, 16'h3003, 16'h0000, "R4 misaligned read returns zero");
        chk(bus_cnt == b0, "R4 no bus access on misalign", 36'(bus_cnt), 36'(b0));
        cmd_read(8'hE8, 16'h3004, mem_model(1'b0, 16'h3004), "R4 aligned read after error");
        chk(cmd_err, "R4 error sticky", 36'(cmd_err), 36'h1);

        // R10 steal after busy budget
        bus_idle = 1'b0;
        exp_wr.push_back({1'b0, 2'b11, 16'h5010, 16'h1234});
        wr_tag.push_back("R10 stolen write");
        send(8'hC8); send(8'h50); send(8'h10); send(8'h12); send(8'h34);
        n = 1;
        while (!bus_req && n < STEAL_WAIT + 5) begin
            @(negedge clk);
            n++;
        end
        chk(n == STEAL_WAIT, "R10 steal cycle", 36'(n), 36'(STEAL_WAIT));
        chk(cpu_freeze, "R10 freeze on stolen cycle", 36'(cpu_freeze), 36'h1);
        @(negedge clk);
        chk(!cpu_freeze, "R10 freeze one cycle", 36'(cpu_freeze), 36'h0);
        bus_idle = 1'b1;
        repeat (4) @(negedge clk);

        chk(exp_rd.size() == 0 && exp_wr.size() == 0, "R2 scoreboard drained",
            36'({exp_rd.size(), exp_wr.size()}), 36'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule